// File: doc/BRIEF.md
# Bus Restart Silence Watch and Wake-Up Contention Resolver

This block supervises the restart of a time-triggered bus after total loss of communication. It observes one activity indicator per replicated bus line. Once every line has been quiet for a configured number of consecutive cycles, it asks an independent checking unit to confirm the silence. If the checker confirms, the block drives a wake-up burst on all lines at once. If the checker disagrees, the block latches a fault and stays off the bus.

Several nodes may reach the silence decision in the same cycle. The block settles this without sensing collisions. After its first burst, a node listens for a quiet window whose length grows with its identity. Any activity during that window means a node with a lower identity is already re-sending, so this node defers and goes back to listening. A window that stays silent lets the node send a second burst, which completes the restart. The lowest identity therefore wins, and the worst-case restart time is fixed by the parameters. This bound lets an integrator size the timing against an outage budget of a few control cycles, on the order of 50 ms.

The block has no streaming data path: the wake-up pattern is a fixed serial waveform clocked out while the transmit enables are high, so the block has no valid/ready handshake and no back-pressure. All pins are plain control and status signals. `node_id` must be held constant while the node is running.

Top module: `bus_restart_arbiter`

## Requirements
- R1: After reset, `tx_en` is all zeros and `wake_pat`, `restart_done` and `chk_fault` are 0.
- R2: A wake-up burst starts only after SILENCE_CYC consecutive clock edges with `line_act` all zeros. `tx_en` rises in the cycle after the last of those edges. An edge with any line active restarts the count from zero.
- R3: During a burst, every bit of `tx_en` is 1 for exactly WAKE_LEN cycles. `line_act` is ignored while sending, because the node's own echo is expected.
- R4: `wake_pat` is 1 in the first cycle of each burst and toggles in every following burst cycle. It is 0 whenever `tx_en` is 0.
- R5: `chk_agree` is sampled at the edge where the silence decision is taken. If it is 0, `chk_fault` goes to 1 and stays at 1 until reset, and `tx_en` stays zero.
- R6: After the first burst, the node waits a quiet window of (node_id+1)*SLOT_CYC cycles. If any line is active in any cycle of that window, the node sends nothing further and returns to listening with the silence count restarted. A full SILENCE_CYC of silence is then needed before it tries again.
- R7: If the window stays silent, a second burst of WAKE_LEN cycles follows at once. After it, `restart_done` is 1 for exactly one cycle with `tx_en` zero, and the node then returns to listening.
- R8: With all lines silent from the start of listening, `restart_done` is observed exactly SILENCE_CYC + 2*WAKE_LEN + (node_id+1)*SLOT_CYC cycles later. This is the bounded worst case for the highest identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_act | input | LINES | Per-line activity seen this cycle |
| chk_agree | input | 1 | Independent checker confirms total silence |
| node_id | input | ID_W | Static identity of this node; lower wins |
| tx_en | output | LINES | Per-line transmit enable, all driven together |
| wake_pat | output | 1 | Serial wake-up waveform, valid while `tx_en` is high |
| restart_done | output | 1 | One-cycle pulse when this node completed the restart |
| chk_fault | output | 1 | Sticky flag: checker rejected the silence decision |

## Verification
Random activity bursts separated by quiet gaps shorter than the silence interval show that a partly quiet bus never triggers a burst. A clean silent run immediately afterwards shows that the count restarts at the last active edge and not at an earlier one. Identities are drawn at random, and activity is injected at random offsets inside the quiet window, including its first and last cycle. This separates correct deferral from an off-by-one window length, and correct completion from a node that ignores its competitor. Echo on every line during the node's own bursts shows that self-reception is not taken as contention. A rejected checker decision, followed by long silence with the checker agreeing, shows that the fault latches and that the node never transmits afterwards.

// File: rtl/wkup_pkg.sv
`timescale 1ns/1ps
package wkup_pkg;
  typedef enum logic [2:0] {
    WS_LISTEN,
    WS_BURST1,
    WS_HOLD,
    WS_BURST2,
    WS_DONE,
    WS_FAULT
  } wk_state_e;
endpackage

// File: rtl/wkup_silence_mon.sv
`timescale 1ns/1ps
module wkup_silence_mon #(
  parameter int LINES       = 2,
  parameter int SILENCE_CYC = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LINES-1:0] line_act,
  output logic             expired
);
  localparam int CW = $clog2(SILENCE_CYC + 1);
  logic [CW-1:0] quiet_cnt;
  logic          any_act;

  assign any_act = |line_act;
  assign expired = enable && !any_act && (quiet_cnt == CW'(SILENCE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                quiet_cnt <= '0;
    else if (!enable || any_act) quiet_cnt <= '0;
    else if (!expired)         quiet_cnt <= quiet_cnt + CW'(1);
  end

  // R2: any active line restarts the silence count
  p_act_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    any_act |=> (quiet_cnt == '0));
endmodule

// File: rtl/wkup_phase_timer.sv
`timescale 1ns/1ps
module wkup_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count + W'(1);
  end
endmodule

// File: rtl/bus_restart_arbiter.sv
`timescale 1ns/1ps
module bus_restart_arbiter
  import wkup_pkg::*;
#(
  parameter int LINES       = 2,
  parameter int ID_W        = 4,
  parameter int SILENCE_CYC = 2000,
  parameter int WAKE_LEN    = 16,
  parameter int SLOT_CYC    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] line_act,
  input  logic             chk_agree,
  input  logic [ID_W-1:0]  node_id,
  output logic [LINES-1:0] tx_en,
  output logic             wake_pat,
  output logic             restart_done,
  output logic             chk_fault
);
  localparam int WIN_W  = ID_W + $clog2(SLOT_CYC + 1) + 1;
  localparam int BRST_W = $clog2(WAKE_LEN + 1);
  localparam int PH_W   = (WIN_W > BRST_W) ? WIN_W : BRST_W;

  wk_state_e        st, nxt;
  logic             sil_expired;
  logic [PH_W-1:0]  ph;
  logic [PH_W-1:0]  win_last;
  logic [PH_W-1:0]  burst_last;
  logic             sending;
  logic             bus_busy;

  assign bus_busy   = |line_act;
  assign burst_last = PH_W'(WAKE_LEN - 1);
  assign win_last   = (PH_W'(node_id) + PH_W'(1)) * PH_W'(SLOT_CYC) - PH_W'(1);

  wkup_silence_mon #(.LINES(LINES), .SILENCE_CYC(SILENCE_CYC)) u_sil (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (st == WS_LISTEN),
    .line_act (line_act),
    .expired  (sil_expired)
  );

  wkup_phase_timer #(.W(PH_W)) u_ph (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (nxt != st),
    .count (ph)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      WS_LISTEN: if (sil_expired) nxt = chk_agree ? WS_BURST1 : WS_FAULT;
      WS_BURST1: if (ph == burst_last) nxt = WS_HOLD;
      WS_HOLD: begin
        if (bus_busy)            nxt = WS_LISTEN;
        else if (ph == win_last) nxt = WS_BURST2;
      end
      WS_BURST2: if (ph == burst_last) nxt = WS_DONE;
      WS_DONE:   nxt = WS_LISTEN;
      WS_FAULT:  nxt = WS_FAULT;
      default:   nxt = WS_LISTEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= WS_LISTEN;
    else        st <= nxt;
  end

  assign sending      = (st == WS_BURST1) || (st == WS_BURST2);
  assign wake_pat     = sending & ~ph[0];
  assign restart_done = (st == WS_DONE);
  assign chk_fault    = (st == WS_FAULT);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    assign tx_en[g] = sending;
  end

  // R2: a burst out of listening follows a quiet edge and an expired count
  p_start_after_silence_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en[0]) && $past(st) == WS_LISTEN) |-> ($past(line_act) == '0 && $past(sil_expired)));
  // R3: all lines are enabled together
  p_lines_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en == '0) || (tx_en == '1));
  // R4: burst opens with a 1 and alternates
  p_first_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en[0]) |-> wake_pat);
  p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en[0] && $past(tx_en[0])) |-> (wake_pat != $past(wake_pat)));
  // R5: fault is sticky and silent
  p_fault_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |-> (tx_en == '0));
  p_fault_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |=> chk_fault);
  // R6: activity in the quiet window forces deferral
  p_defer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == WS_HOLD && bus_busy) |=> (st == WS_LISTEN && tx_en == '0));
  // R7: completion is a single-cycle pulse with the bus released
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_done |=> (!restart_done && tx_en == '0));
endmodule

// File: tb/bus_restart_arbiter_tb.sv
`timescale 1ns/1ps
module bus_restart_arbiter_tb_top;
  localparam int NL   = 3;
  localparam int IDW  = 3;
  localparam int SIL  = 16;
  localparam int WAKE = 6;
  localparam int SLOT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NL-1:0] line_act = '0;
  logic chk_agree = 1'b1;
  logic [IDW-1:0] node_id = '0;
  logic [NL-1:0] tx_en;
  logic wake_pat, restart_done, chk_fault;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_restart_arbiter #(.LINES(NL), .ID_W(IDW), .SILENCE_CYC(SIL),
                        .WAKE_LEN(WAKE), .SLOT_CYC(SLOT)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_act(line_act), .chk_agree(chk_agree),
    .node_id(node_id), .tx_en(tx_en), .wake_pat(wake_pat),
    .restart_done(restart_done), .chk_fault(chk_fault));

  function automatic int win_len(input int id);
    return (id + 1) * SLOT;
  endfunction

  function automatic int done_latency(input int id);
    return SIL + 2 * WAKE + win_len(id);
  endfunction

  function automatic logic [NL-1:0] rand_act();
    return NL'($urandom_range(1, (1 << NL) - 1));
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int actual, input int expected);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    line_act = '0;
    chk_agree = 1'b1;
    tick(); tick();
    rst_n = 1'b1;
    chk(tx_en == '0 && !wake_pat && !restart_done && !chk_fault, "R1 reset state",
        {tx_en, wake_pat, restart_done, chk_fault}, 0);
  endtask

  // Noise with quiet gaps shorter than the silence interval: never a burst (R2)
  task automatic noise(input int bursts);
    for (int b = 0; b < bursts; b++) begin
      int gap = $urandom_range(0, SIL - 2);
      for (int q = 0; q < gap; q++) begin
        line_act = '0; tick();
        chk(tx_en == '0, "R2 no burst before full silence", tx_en, 0);
      end
      line_act = rand_act(); tick();
      chk(tx_en == '0, "R2 no burst on active edge", tx_en, 0);
    end
  endtask

  // SIL quiet edges, burst observed after the last one; ticks counted in *n
  task automatic silence_to_burst(inout int n);
    for (int j = 1; j <= SIL; j++) begin
      line_act = '0; chk_agree = 1'b1; tick(); n++;
      if (j < SIL) chk(tx_en == '0, "R2 still counting silence", tx_en, 0);
      else chk(tx_en == '1 && wake_pat, "R2 burst starts after silence", {tx_en, wake_pat}, {{NL{1'b1}}, 1'b1});
    end
  endtask

  // first cycle already observed; echo on all lines while sending
  task automatic finish_burst(inout int n);
    for (int i = 1; i < WAKE; i++) begin
      line_act = '1; tick(); n++;
      chk(tx_en == '1, "R3 all lines held during burst", tx_en, (1 << NL) - 1);
      chk(wake_pat == ((i % 2) == 0), "R4 pattern alternates", wake_pat, (i % 2) == 0);
    end
    line_act = '1; tick(); n++;
    chk(tx_en == '0 && !wake_pat, "R3 burst length", {tx_en, wake_pat}, 0);
  endtask

  // full restart; defer_at < 0 means no competitor
  task automatic restart(input int id, input int defer_at);
    int n = 0;
    int w = win_len(id);
    node_id = IDW'(id);
    silence_to_burst(n);
    finish_burst(n);
    for (int k = 0; k < w; k++) begin
      if (k == defer_at) begin
        line_act = rand_act(); tick();
        chk(tx_en == '0 && !restart_done, "R6 deferred on activity in window", tx_en, 0);
        // count must have restarted: a full silence is needed again
        n = 0;
        silence_to_burst(n);
        finish_burst(n);
        for (int m = 0; m < w; m++) begin
          line_act = '0; tick(); n++;
          if (m < w - 1) chk(tx_en == '0, "R6 quiet window held", tx_en, 0);
        end
        k = w;
      end else begin
        line_act = '0; tick(); n++;
        if (k < w - 1) chk(tx_en == '0, "R6 quiet window held", tx_en, 0);
      end
    end
    chk(tx_en == '1 && wake_pat, "R7 second burst after silent window", {tx_en, wake_pat}, {{NL{1'b1}}, 1'b1});
    for (int i = 1; i < WAKE; i++) begin
      line_act = '1; tick(); n++;
      chk(tx_en == '1 && wake_pat == ((i % 2) == 0), "R4 second burst pattern", {tx_en, wake_pat}, {{NL{1'b1}}, 1'((i % 2) == 0)});
    end
    line_act = '1; tick(); n++;
    chk(restart_done && tx_en == '0, "R7 done pulse", {restart_done, tx_en}, {1'b1, {NL{1'b0}}});
    chk(n == done_latency(id), "R8 restart latency", n, done_latency(id));
    line_act = '0; tick();
    chk(!restart_done && tx_en == '0, "R7 done lasts one cycle", restart_done, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    node_id = '0;
    do_reset();

    // directed corners: lowest and highest id, defer at first and last window cycle
    noise(5);
    restart(0, -1);
    restart(7, -1);
    restart(2, 0);
    restart(4, win_len(4) - 1);

    // R5: checker disagreement at decision edge
    do_reset();
    node_id = IDW'(1);
    for (int j = 1; j <= SIL; j++) begin
      line_act = '0;
      chk_agree = (j == SIL) ? 1'b0 : 1'b1;
      tick();
    end
    chk(chk_fault && tx_en == '0, "R5 fault raised, no burst", {chk_fault, tx_en}, {1'b1, {NL{1'b0}}});
    for (int j = 0; j < 3 * SIL; j++) begin
      line_act = (j % 7 == 3) ? rand_act() : '0;
      chk_agree = 1'b1;
      tick();
      chk(chk_fault && tx_en == '0, "R5 fault sticky and silent", {chk_fault, tx_en}, {1'b1, {NL{1'b0}}});
    end
    do_reset();

    // constrained random mix
    for (int it = 0; it < 40; it++) begin
      int id = $urandom_range(0, (1 << IDW) - 1);
      int d = ($urandom_range(0, 2) == 0) ? -1 : $urandom_range(0, win_len(id) - 1);
      noise($urandom_range(0, 4));
      restart(id, d);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    finished = 1;
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule